// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block decides the outcome of atomic reservation operations when a write-class cache request completes. It keeps a small table of reserved cache lines. Each entry holds a line address and the requester ID that reserved it. A load-linked completion places or refreshes a reservation. A store-conditional succeeds only while its requester still holds the line's reservation. Stores, flushes and other write-class completions by the owner cancel the reservation.

The completion logic raises `done_i` for one cycle per completed request and presents the request kind, the line address and the requester ID. In the same cycle the block returns a success bit and the value handed back to the processor for a store-conditional. For the two halves of a locked read-modify-write sequence it also returns a command that blocks or unblocks the line's incoming request queue. A bypass input is used for interconnect stress runs. With it set, the table is left alone and every completion reports success.

Top module: `resv_monitor`

## Requirements
- R1: After reset no line is reserved, so a store-conditional to any line fails.
- R2: A load-linked (kind 3) always reports success. From the next cycle on, its line is reserved for its requester, and a store-conditional (kind 4) from that requester to that line reports success with `result_o` = 1.
- R3: A store-conditional whose line is not reserved, or is reserved by a different requester ID, reports `ok_o` = 0 and `result_o` = 0.
- R4: Every store-conditional removes its line's reservation, whatever its outcome and whichever requester issued it.
- R5: A store (2), flush (8), read-for-ownership (5), locked read (6) or locked write (7) removes the line's reservation only when the line is reserved by the same requester. When another requester holds the line, the reservation stays.
- R6: Load (0), instruction fetch (1) and unassigned kinds (9 to 15) always report success and never change any reservation.
- R7: A locked read completion raises `block_o`, and a locked write completion raises `unblock_o`, for the line on `line_i` in that cycle. This holds in bypass mode as well.
- R8: While `bypass_i` is 1, every completion reports `ok_o` = 1 (and `result_o` = 1 for a store-conditional), and no reservation is set or removed.
- R9: The table tracks DEPTH distinct lines. A load-linked to an untracked line while the table is full replaces the line whose most recent load-linked is oldest. A load-linked to a tracked line makes that line the newest.
- R10: A load-linked to a line already reserved by another requester moves the reservation to the new requester.
- R11: All outputs are 0 while `done_i` is 0. The outputs are a combinational function of the current completion and the table, and table changes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | One completed request this cycle |
| kind_i | input | 4 | Request kind code (see requirements) |
| line_i | input | LINE_W | Line address of the completed request |
| who_i | input | ID_W | Requester ID |
| bypass_i | input | 1 | Skip reservation handling; report success |
| ok_o | output | 1 | Completion succeeded |
| result_o | output | 1 | Store-conditional value returned: 1 success, 0 failure |
| block_o | output | 1 | Block the queue of `line_i` |
| unblock_o | output | 1 | Unblock the queue of `line_i` |

## Verification
The bench builds the monitor with DEPTH = 4, LINE_W = 8 and ID_W = 2. With a four-entry table, a full table and replacement of the oldest line are reached after only a handful of load-linked operations. Both the plain replacement order and the order after a refresh by a repeated load-linked are tested. The 2-bit ID allows several requesters to compete for one line, which covers ownership transfer and a foreign store that must leave another requester's reservation intact.

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [3:0]        kind_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [ID_W-1:0]   who_i,
  input  logic              bypass_i,
  output logic              ok_o,
  output logic              result_o,
  output logic              block_o,
  output logic              unblock_o
);
  localparam int RW = $clog2(DEPTH);
  localparam logic [3:0] K_LD = 4'd0, K_IF = 4'd1, K_LL = 4'd3, K_SC = 4'd4;
  localparam logic [3:0] K_LRD = 4'd6, K_LWR = 4'd7, K_FL = 4'd8;

  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] tag_q  [DEPTH];
  logic [ID_W-1:0]   own_q  [DEPTH];
  logic [RW-1:0]     rank_q [DEPTH];

  logic [DEPTH-1:0] hit_v;
  logic [RW-1:0]    hit_idx, free_idx, old_idx, set_idx;
  logic             free_any;
  logic [RW:0]      cnt, set_rank, clr_rank;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_v[g] = vld_q[g] && (tag_q[g] == line_i);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    free_any = 1'b0;
    cnt      = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_v[i]) hit_idx = RW'(i);
      if (!vld_q[i]) begin
        free_idx = RW'(i);
        free_any = 1'b1;
      end
      if (vld_q[i] && rank_q[i] == RW'(DEPTH - 1)) old_idx = RW'(i);
      cnt = cnt + (RW+1)'(vld_q[i]);
    end
  end

  wire hit_any = |hit_v;
  wire owned   = hit_any && (own_q[hit_idx] == who_i);
  wire is_ll   = kind_i == K_LL;
  wire is_sc   = kind_i == K_SC;
  wire is_rd   = (kind_i == K_LD) || (kind_i == K_IF) || (kind_i > K_FL);
  wire act     = done_i && !bypass_i;
  wire do_set  = act && is_ll;
  wire do_clr  = act && ((is_sc && hit_any) || (!is_rd && !is_sc && !is_ll && owned));

  assign set_idx  = hit_any ? hit_idx : (free_any ? free_idx : old_idx);
  assign set_rank = (hit_any || !free_any) ? {1'b0, rank_q[set_idx]} : cnt;
  assign clr_rank = {1'b0, rank_q[hit_idx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i]  <= '0;
        own_q[i]  <= '0;
        rank_q[i] <= '0;
      end
    end else if (do_set) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (RW'(i) == set_idx) begin
          vld_q[i]  <= 1'b1;
          tag_q[i]  <= line_i;
          own_q[i]  <= who_i;
          rank_q[i] <= '0;
        end else if (vld_q[i] && {1'b0, rank_q[i]} < set_rank) begin
          rank_q[i] <= rank_q[i] + 1'b1;
        end
      end
    end else if (do_clr) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (RW'(i) == hit_idx) begin
          vld_q[i] <= 1'b0;
        end else if (vld_q[i] && {1'b0, rank_q[i]} > clr_rank) begin
          rank_q[i] <= rank_q[i] - 1'b1;
        end
      end
    end
  end

  assign ok_o      = done_i && (bypass_i || !is_sc || owned);
  assign result_o  = ok_o && is_sc;
  assign block_o   = done_i && (kind_i == K_LRD);
  assign unblock_o = done_i && (kind_i == K_LWR);
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_i,
  input logic [3:0]        kind_i,
  input logic [LINE_W-1:0] line_i,
  input logic [ID_W-1:0]   who_i,
  input logic              bypass_i,
  input logic              ok_o,
  input logic              result_o,
  input logic              block_o,
  input logic              unblock_o,
  input logic [DEPTH-1:0]  hit_v
);
  wire sc_now = done_i && kind_i == 4'd4 && !bypass_i;

  AST_LL_THEN_SC: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(done_i && kind_i == 4'd3 && !bypass_i) && sc_now &&
    line_i == $past(line_i) && who_i == $past(who_i) |-> ok_o && result_o); // R2
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(sc_now) && sc_now && line_i == $past(line_i) |-> !ok_o); // R4
  AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(done_i && kind_i == 4'd2 && !bypass_i) && sc_now &&
    line_i == $past(line_i) && who_i == $past(who_i) |-> !ok_o); // R5
  AST_RESULT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    result_o |-> ok_o && done_i); // R3
  AST_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && kind_i <= 4'd1 |-> ok_o && !result_o); // R6
  AST_BYPASS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && bypass_i |-> ok_o); // R8
  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_v)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> !ok_o && !result_o && !block_o && !unblock_o); // R11
endmodule

bind resv_monitor resv_monitor_chk #(.DEPTH(DEPTH), .LINE_W(LINE_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_i(done_i), .kind_i(kind_i), .line_i(line_i),
  .who_i(who_i), .bypass_i(bypass_i), .ok_o(ok_o), .result_o(result_o),
  .block_o(block_o), .unblock_o(unblock_o), .hit_v(hit_v)
);

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;
  localparam int NV = 43;
  // fields: kind, line, who, bypass, requirement, expected {ok,result,block,unblock}
  localparam logic [22:0] VEC [NV] = '{
    {4'd4, 8'd10, 2'd1, 1'b0, 4'd1,  4'b0000},  // R1 nothing reserved
    {4'd3, 8'd10, 2'd1, 1'b0, 4'd2,  4'b1000},  // R2
    {4'd4, 8'd10, 2'd1, 1'b0, 4'd2,  4'b1100},  // R2
    {4'd4, 8'd10, 2'd1, 1'b0, 4'd4,  4'b0000},  // R4 successful SC cleared
    {4'd3, 8'd10, 2'd1, 1'b0, 4'd2,  4'b1000},
    {4'd4, 8'd10, 2'd2, 1'b0, 4'd3,  4'b0000},  // R3 wrong ID
    {4'd4, 8'd10, 2'd1, 1'b0, 4'd4,  4'b0000},  // R4 failed SC also cleared
    {4'd3, 8'd11, 2'd1, 1'b0, 4'd2,  4'b1000},
    {4'd0, 8'd11, 2'd2, 1'b0, 4'd6,  4'b1000},  // R6 load
    {4'd1, 8'd11, 2'd1, 1'b0, 4'd6,  4'b1000},  // R6 fetch
    {4'd4, 8'd11, 2'd1, 1'b0, 4'd6,  4'b1100},  // R6 reservation intact
    {4'd3, 8'd12, 2'd1, 1'b0, 4'd2,  4'b1000},
    {4'd2, 8'd12, 2'd2, 1'b0, 4'd5,  4'b1000},  // R5 foreign store
    {4'd4, 8'd12, 2'd1, 1'b0, 4'd5,  4'b1100},  // R5 still held
    {4'd3, 8'd12, 2'd1, 1'b0, 4'd2,  4'b1000},
    {4'd2, 8'd12, 2'd1, 1'b0, 4'd5,  4'b1000},  // R5 own store
    {4'd4, 8'd12, 2'd1, 1'b0, 4'd5,  4'b0000},  // R5 killed
    {4'd3, 8'd13, 2'd1, 1'b0, 4'd2,  4'b1000},
    {4'd8, 8'd13, 2'd1, 1'b0, 4'd5,  4'b1000},  // R5 flush
    {4'd4, 8'd13, 2'd1, 1'b0, 4'd5,  4'b0000},
    {4'd3, 8'd17, 2'd3, 1'b0, 4'd2,  4'b1000},
    {4'd5, 8'd17, 2'd3, 1'b0, 4'd5,  4'b1000},  // R5 read-for-ownership
    {4'd4, 8'd17, 2'd3, 1'b0, 4'd5,  4'b0000},
    {4'd3, 8'd14, 2'd2, 1'b0, 4'd2,  4'b1000},
    {4'd6, 8'd14, 2'd2, 1'b0, 4'd7,  4'b1010},  // R7 block
    {4'd4, 8'd14, 2'd2, 1'b0, 4'd5,  4'b0000},  // R5 locked read kills
    {4'd7, 8'd14, 2'd2, 1'b0, 4'd7,  4'b1001},  // R7 unblock
    {4'd3, 8'd15, 2'd0, 1'b1, 4'd8,  4'b1000},  // R8 LL ignored
    {4'd4, 8'd15, 2'd0, 1'b0, 4'd8,  4'b0000},
    {4'd3, 8'd15, 2'd0, 1'b0, 4'd2,  4'b1000},
    {4'd4, 8'd15, 2'd0, 1'b1, 4'd8,  4'b1100},  // R8 SC does not clear
    {4'd4, 8'd15, 2'd0, 1'b0, 4'd8,  4'b1100},
    {4'd3, 8'd16, 2'd1, 1'b0, 4'd10, 4'b1000},
    {4'd3, 8'd16, 2'd2, 1'b0, 4'd10, 4'b1000},  // R10 transfer
    {4'd4, 8'd16, 2'd2, 1'b0, 4'd10, 4'b1100},
    {4'd3, 8'd16, 2'd1, 1'b0, 4'd10, 4'b1000},
    {4'd3, 8'd16, 2'd2, 1'b0, 4'd10, 4'b1000},
    {4'd4, 8'd16, 2'd1, 1'b0, 4'd10, 4'b0000},  // R10 old owner lost it
    {4'd6, 8'd18, 2'd1, 1'b1, 4'd7,  4'b1010},  // R7 block under bypass
    {4'd4, 8'd19, 2'd3, 1'b1, 4'd8,  4'b1100},  // R8
    {4'd3, 8'd20, 2'd0, 1'b0, 4'd2,  4'b1000},
    {4'd9, 8'd20, 2'd0, 1'b0, 4'd6,  4'b1000},  // R6 unassigned kind
    {4'd4, 8'd20, 2'd0, 1'b0, 4'd6,  4'b1100}
  };

  logic clk = 1'b0, rst_n = 1'b0, done_i = 1'b0, bypass_i = 1'b0;
  logic [3:0] kind_i = '0;
  logic [7:0] line_i = '0;
  logic [1:0] who_i = '0;
  logic ok_o, result_o, block_o, unblock_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  resv_monitor #(.DEPTH(4), .LINE_W(8), .ID_W(2)) i_resv_monitor (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .kind_i(kind_i), .line_i(line_i),
    .who_i(who_i), .bypass_i(bypass_i), .ok_o(ok_o), .result_o(result_o),
    .block_o(block_o), .unblock_o(unblock_o));

  task automatic check(input int rq, input logic [3:0] exp);
    logic [3:0] got;
    got = {ok_o, result_o, block_o, unblock_o};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d line=%0d kind=%0d actual=%b expected=%b", rq, line_i, kind_i, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] k, input logic [7:0] ln, input logic [1:0] w,
                       input logic b, input int rq, input logic [3:0] exp);
    @(negedge clk);
    done_i = 1'b1; kind_i = k; line_i = ln; who_i = w; bypass_i = b;
    #2 check(rq, exp);
  endtask

  task automatic idle(input int rq);
    @(negedge clk);
    done_i = 1'b0; bypass_i = 1'b0;
    #2 check(rq, 4'b0000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; done_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    idle(1);   // R1 quiet reset state
    for (int v = 0; v < NV; v++)
      apply(VEC[v][22:19], VEC[v][18:11], VEC[v][10:9], VEC[v][8], int'(VEC[v][7:4]), VEC[v][3:0]);
    apply(4'd3, 8'd30, 2'd1, 1'b0, 11, 4'b1000);
    idle(11);  // R11 outputs follow done_i
    // R9 plain replacement of the oldest line
    do_reset();
    apply(4'd4, 8'd30, 2'd1, 1'b0, 1, 4'b0000);  // R1 reset cleared the table
    for (int l = 40; l < 44; l++) apply(4'd3, 8'(l), 2'd1, 1'b0, 9, 4'b1000);
    apply(4'd3, 8'd44, 2'd1, 1'b0, 9, 4'b1000);
    apply(4'd4, 8'd40, 2'd1, 1'b0, 9, 4'b0000);  // R9 evicted
    apply(4'd4, 8'd41, 2'd1, 1'b0, 9, 4'b1100);
    apply(4'd4, 8'd44, 2'd1, 1'b0, 9, 4'b1100);
    // R9 refresh by repeated load-linked, with transfer (R10)
    do_reset();
    for (int l = 50; l < 54; l++) apply(4'd3, 8'(l), 2'd1, 1'b0, 9, 4'b1000);
    apply(4'd3, 8'd50, 2'd2, 1'b0, 10, 4'b1000);
    apply(4'd3, 8'd54, 2'd1, 1'b0, 9, 4'b1000);
    apply(4'd4, 8'd51, 2'd1, 1'b0, 9, 4'b0000);  // R9 oldest after refresh
    apply(4'd4, 8'd50, 2'd2, 1'b0, 10, 4'b1100);
    apply(4'd4, 8'd52, 2'd1, 1'b0, 9, 4'b1100);
    idle(11);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule